// File: doc/BRIEF.md
# Converter Host Bus Port

This block is the processor-facing side of a four-channel successive-approximation converter. A host drives active-low chip-select, read and write strobes, a byte selector for reads, a register-select line, a two-bit channel address and an eight-bit write data byte. The block turns these into single-cycle requests to the conversion engine: start a conversion, run a calibration, and the channel to convert. It also keeps a small mode register that the host writes when the register-select line is high.

Reads return the twelve-bit result one byte at a time. The low byte carries result bits 7..0. The high byte carries result bits 11..8 in its lower nibble, zeros in bits 6..4, and a live busy flag in bit 7. A dual-purpose input pin either requests calibration or acts as an external sample-to-hold trigger that starts a conversion. The mode register selects which of the two it does.

All host pins are asynchronous to the system clock. They pass through two-flop synchronizers, and every edge is detected after synchronization. The engine connects through the start, calibrate, busy and result ports.

Top module: `adc_host_port`

## Requirements
- R1: A write cycle ends when the window in which both chip select and write are low closes, whether write or chip select rises first. With the register-select line low, each such end produces exactly one conv_start pulse, one clock long, within four clocks of the closing strobe.
- R2: On the end of a conversion write, chan_sel takes the value of the address pins (00, 01, 10 and 11 select channels 0, 1, 2 and 3). It holds that value until the next conversion write.
- R3: While a read is active and byte_sel is low, data_out equals result bits 7..0.
- R4: While a read is active and byte_sel is high, data_out[3:0] equals result bits 11..8, data_out[6:4] is zero, and data_out[7] is 1 exactly when busy_conv or busy_cal is high at that moment.
- R5: data_oe is 1 only while both chip select and read are low (after synchronization). Otherwise data_oe is 0 and data_out is all zero.
- R6: A write with the register-select line high is a mode-register write and never starts a conversion or changes chan_sel. Data bit 1 set produces exactly one cal_req pulse, because the bit clears itself. Data bit 2 is stored as the pin mode (0 = calibrate, 1 = sample trigger).
- R7: In pin mode 0, a rising edge on cal_trig_n produces one cal_req pulse. Its falling edge produces nothing.
- R8: In pin mode 1, a rising edge on cal_trig_n produces one conv_start pulse and no cal_req.
- R9: While busy_cal is high, conversion starts from writes and from the pin are dropped, but calibration requests are still issued.
- R10: A write strobe pulsed while chip select stays high has no effect: no pulses, and chan_sel is unchanged.
- R11: After reset, conv_start and cal_req are 0, data_oe is 0, chan_sel is 0, and the pin mode is 0 (calibrate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| byte_sel | input | 1 | Read byte selector (1 = high byte) |
| reg_sel | input | 1 | 1 = writes go to the mode register |
| addr | input | 2 | Channel address |
| cal_trig_n | input | 1 | Dual-purpose calibrate / sample-trigger pin |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | Output enable for the external bus driver |
| busy_conv | input | 1 | Engine is converting |
| busy_cal | input | 1 | Engine is calibrating |
| result | input | 12 | Latest conversion result |
| conv_start | output | 1 | One-cycle conversion start request |
| cal_req | output | 1 | One-cycle calibration request |
| chan_sel | output | 2 | Latched channel number |

## Verification
The bench targets the two ways a write can end. A decoder that watches only the write strobe misses a cycle that chip select closes. One that sees both edges starts twice for a single access. A mode-register write that sets the calibrate bit is repeated to confirm that exactly one request appears each time; a bit that fails to clear would request on every cycle. The pin is driven in both modes, so a mix-up between its roles shows up as a calibration where a start is expected, or the reverse. It also confirms that a falling edge alone triggers nothing. High-byte reads are taken with the busy inputs toggled, which catches a stale or swapped status bit and any padding that is not zero.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int DATA_W = 8;
  localparam int RES_W  = 12;
  localparam int ADDR_W = 2;
  localparam int HI_W   = RES_W - DATA_W;
  localparam int PAD_W  = DATA_W - 1 - HI_W;

  typedef struct packed {
    logic              cs_n;
    logic              rd_n;
    logic              wr_n;
    logic              cal_n;
    logic              bsel;
    logic              rsel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] din;
  } host_pins_t;

  localparam int PINS_W = $bits(host_pins_t);

  // mode register bit positions
  localparam int MODE_CAL_BIT  = 1;
  localparam int MODE_HOLD_BIT = 2;

  function automatic host_pins_t idle_pins();
    host_pins_t p;
    p      = '0;
    p.cs_n = 1'b1;
    p.rd_n = 1'b1;
    p.wr_n = 1'b1;
    p.cal_n = 1'b1;
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] low_byte(input logic [RES_W-1:0] r);
    return r[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] high_byte(input logic [RES_W-1:0] r,
                                                  input logic busy);
    return {busy, {PAD_W{1'b0}}, r[RES_W-1:DATA_W]};
  endfunction

  function automatic logic write_open(input host_pins_t p);
    return ~p.cs_n & ~p.wr_n;
  endfunction
endpackage

// File: rtl/ahp_sync.sv
module ahp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] stg [STAGES+1];

  genvar i;
  generate
    for (i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign sync_q = stg[STAGES-1];
  assign prev_q = stg[STAGES];
endmodule

// File: rtl/ahp_cmd_decode.sv
module ahp_cmd_decode
  import adc_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  host_pins_t        cur,
  input  host_pins_t        prv,
  input  logic              busy_cal,
  output logic              write_end,
  output logic              conv_write,
  output logic              mode_write,
  output logic              pin_rise,
  output logic              hold_mode,
  output logic              mode_cal_bit,
  output logic              conv_start,
  output logic              cal_req,
  output logic [ADDR_W-1:0] chan_sel
);
  logic start_d, cal_d;

  always_comb begin
    write_end  = write_open(prv) & ~write_open(cur);
    conv_write = write_end & ~prv.rsel;
    mode_write = write_end &  prv.rsel;
    pin_rise   = cur.cal_n & ~prv.cal_n;
    start_d    = (conv_write | (pin_rise & hold_mode)) & ~busy_cal;
    cal_d      = mode_cal_bit | (pin_rise & ~hold_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_mode    <= 1'b0;
      mode_cal_bit <= 1'b0;
      conv_start   <= 1'b0;
      cal_req      <= 1'b0;
      chan_sel     <= '0;
    end else begin
      conv_start   <= start_d;
      cal_req      <= cal_d;
      mode_cal_bit <= mode_write & prv.din[MODE_CAL_BIT];
      if (mode_write) hold_mode <= prv.din[MODE_HOLD_BIT];
      if (conv_write) chan_sel  <= prv.addr;
    end
  end
endmodule

// File: rtl/ahp_read_mux.sv
module ahp_read_mux
  import adc_host_pkg::*;
(
  input  host_pins_t        cur,
  input  logic [RES_W-1:0]  result,
  input  logic              busy_any,
  output logic              rd_active,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  always_comb begin
    rd_active = ~cur.cs_n & ~cur.rd_n;
    data_oe   = rd_active;
    if (!rd_active)   data_out = '0;
    else if (cur.bsel) data_out = high_byte(result, busy_any);
    else               data_out = low_byte(result);
  end
endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              byte_sel,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cal_trig_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              busy_conv,
  input  logic              busy_cal,
  input  logic [RES_W-1:0]  result,
  output logic              conv_start,
  output logic              cal_req,
  output logic [ADDR_W-1:0] chan_sel
);
  host_pins_t raw_pins, cur, prv;
  logic [PINS_W-1:0] cur_v, prv_v;
  logic write_end, conv_write, mode_write, pin_rise, hold_mode, mode_cal_bit;
  logic rd_active, busy_any;

  always_comb begin
    raw_pins.cs_n  = cs_n;
    raw_pins.rd_n  = rd_n;
    raw_pins.wr_n  = wr_n;
    raw_pins.cal_n = cal_trig_n;
    raw_pins.bsel  = byte_sel;
    raw_pins.rsel  = reg_sel;
    raw_pins.addr  = addr;
    raw_pins.din   = data_in;
  end

  ahp_sync #(.W(PINS_W), .STAGES(2), .RST_VAL(idle_pins())) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .sync_q(cur_v), .prev_q(prv_v)
  );

  assign cur      = host_pins_t'(cur_v);
  assign prv      = host_pins_t'(prv_v);
  assign busy_any = busy_conv | busy_cal;

  ahp_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prv(prv), .busy_cal(busy_cal),
    .write_end(write_end), .conv_write(conv_write), .mode_write(mode_write),
    .pin_rise(pin_rise), .hold_mode(hold_mode), .mode_cal_bit(mode_cal_bit),
    .conv_start(conv_start), .cal_req(cal_req), .chan_sel(chan_sel)
  );

  ahp_read_mux u_rd (
    .cur(cur), .result(result), .busy_any(busy_any),
    .rd_active(rd_active), .data_out(data_out), .data_oe(data_oe)
  );
endmodule

// File: rtl/adc_host_port_chk.sv
module adc_host_port_chk
  import adc_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              cal_req,
  input logic              busy_cal,
  input logic              conv_write,
  input logic              mode_write,
  input logic              pin_rise,
  input logic              mode_cal_bit,
  input logic              data_oe,
  input logic              bsel_sync,
  input logic [DATA_W-1:0] data_out,
  input logic [ADDR_W-1:0] chan_sel
);
  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_chan_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_write |=> $stable(chan_sel));

  assert_hi_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && bsel_sync) |-> (data_out[6:4] == 3'b000));

  assert_bus_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  assert_mode_selfclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cal_bit |=> !mode_cal_bit);

  assert_cal_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |=> !cal_req);

  assert_mode_nostart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_write && !pin_rise) |=> !conv_start);

  assert_cal_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(!busy_cal));
endmodule

bind adc_host_port adc_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cal_req(cal_req),
  .busy_cal(busy_cal), .conv_write(conv_write), .mode_write(mode_write),
  .pin_rise(pin_rise), .mode_cal_bit(mode_cal_bit), .data_oe(data_oe),
  .bsel_sync(cur.bsel), .data_out(data_out), .chan_sel(chan_sel)
);

// File: tb/adc_host_port_bench.sv
module adc_host_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, byte_sel = 0, reg_sel = 0, cal_trig_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] data_in = 0, data_out;
  logic data_oe, busy_conv = 0, busy_cal = 0, conv_start, cal_req;
  logic [11:0] result = 0;
  logic [1:0] chan_sel;

  int checks = 0, errors = 0, n_start = 0, n_cal = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_host_port u_adc_host_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .byte_sel(byte_sel), .reg_sel(reg_sel), .addr(addr), .cal_trig_n(cal_trig_n),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .busy_conv(busy_conv), .busy_cal(busy_cal), .result(result),
    .conv_start(conv_start), .cal_req(cal_req), .chan_sel(chan_sel)
  );

  always @(negedge clk) begin
    if (conv_start) n_start++;
    if (cal_req)    n_cal++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    idle(2);
    n_start = 0;
    n_cal = 0;
  endtask

  // cs_first_up: chip select rises before write does
  task automatic host_write(input bit rs, input logic [1:0] a, input logic [7:0] d,
                            input bit cs_first_up);
    @(negedge clk);
    cs_n = 0; reg_sel = rs; addr = a; data_in = d;
    idle(2); wr_n = 0; idle(3);
    if (cs_first_up) begin cs_n = 1; idle(2); wr_n = 1; end
    else             begin wr_n = 1; idle(2); cs_n = 1; end
    idle(6);
  endtask

  task automatic pin_pulse();
    @(negedge clk); cal_trig_n = 0; idle(4); cal_trig_n = 1; idle(6);
  endtask

  task automatic host_read(input bit hi, output logic [7:0] v, output logic oe);
    @(negedge clk); cs_n = 0; rd_n = 0; byte_sel = hi;
    idle(4); v = data_out; oe = data_oe;
    rd_n = 1; cs_n = 1; idle(4);
  endtask

  task automatic t_reset();
    chk(conv_start == 0 && cal_req == 0, "R11 pulses", {conv_start, cal_req}, 0);
    chk(data_oe == 0 && data_out == 0, "R11 bus", data_oe, 0);
    chk(chan_sel == 0, "R11 chan", chan_sel, 0);
    clr(); pin_pulse();
    chk(n_cal == 1 && n_start == 0, "R11 pin mode calibrate", n_cal, 1);
  endtask

  task automatic t_conv_writes();
    for (int c = 0; c < 4; c++) begin
      clr(); host_write(0, 2'(3 - c), 8'h00, c[0]);
      chk(n_start == 1, "R1 single start", n_start, 1);
      chk(chan_sel == 2'(3 - c), "R2 channel latch", chan_sel, 3 - c);
    end
    clr(); idle(10);
    chk(chan_sel == 2'd0 && n_start == 0, "R2 channel holds", chan_sel, 0);
  endtask

  task automatic t_no_cs();
    clr();
    @(negedge clk); addr = 2'd2; wr_n = 0; idle(4); wr_n = 1; idle(8);
    chk(n_start == 0 && n_cal == 0, "R10 no pulses", n_start + n_cal, 0);
    chk(chan_sel == 2'd0, "R10 chan unchanged", chan_sel, 0);
  endtask

  task automatic t_reads();
    logic [7:0] v; logic oe;
    result = 12'hA5C;
    host_read(0, v, oe);
    chk(oe == 1 && v == 8'h5C, "R3 low byte", v, 8'h5C);
    busy_conv = 0; busy_cal = 0;
    host_read(1, v, oe);
    chk(v == 8'h0A, "R4 high byte idle", v, 8'h0A);
    busy_conv = 1;
    host_read(1, v, oe);
    chk(v == 8'h8A, "R4 status conv", v, 8'h8A);
    busy_conv = 0; busy_cal = 1; result = 12'h3FF;
    host_read(1, v, oe);
    chk(v == 8'h83, "R4 status cal", v, 8'h83);
    busy_cal = 0;
    @(negedge clk); cs_n = 0; idle(4);
    chk(data_oe == 0 && data_out == 0, "R5 cs only", data_oe, 0);
    cs_n = 1; rd_n = 0; idle(4);
    chk(data_oe == 0 && data_out == 0, "R5 rd only", data_oe, 0);
    rd_n = 1; idle(2);
  endtask

  task automatic t_mode_reg();
    clr(); host_write(1, 2'd3, 8'h02, 0);
    chk(n_cal == 1 && n_start == 0, "R6 cal bit one request", n_cal, 1);
    chk(chan_sel == 2'd0, "R6 chan untouched", chan_sel, 0);
    clr(); host_write(1, 2'd1, 8'h02, 1);
    chk(n_cal == 1, "R6 repeat cal", n_cal, 1);
    clr(); host_write(1, 2'd0, 8'h00, 0); pin_pulse();
    chk(n_cal == 1 && n_start == 0, "R7 pin calibrate", n_cal, 1);
    clr(); @(negedge clk); cal_trig_n = 0; idle(8);
    chk(n_cal == 0, "R7 falling edge ignored", n_cal, 0);
    cal_trig_n = 1; idle(6);
    chk(n_cal == 1, "R7 rising edge", n_cal, 1);
    clr(); host_write(1, 2'd0, 8'h04, 0);
    chk(n_cal == 0 && n_start == 0, "R6 mode write quiet", n_cal + n_start, 0);
    pin_pulse();
    chk(n_start == 1 && n_cal == 0, "R8 pin starts", n_start, 1);
  endtask

  task automatic t_cal_busy();
    clr(); busy_cal = 1;
    pin_pulse();
    chk(n_start == 0, "R9 pin start dropped", n_start, 0);
    host_write(0, 2'd1, 8'h00, 0);
    chk(n_start == 0, "R9 write start dropped", n_start, 0);
    host_write(1, 2'd0, 8'h06, 0);
    chk(n_cal == 1, "R9 cal still issued", n_cal, 1);
    busy_cal = 0;
    clr(); host_write(0, 2'd2, 8'h00, 0);
    chk(n_start == 1 && chan_sel == 2'd2, "R9 start after cal", n_start, 1);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    t_conv_writes();
    t_no_cs();
    t_reads();
    t_mode_reg();
    t_cal_busy();
    done = 1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) chk(0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule